// File: doc/BRIEF.md
# Host Parallel Peripheral Port

This block lets an external host processor treat a small controller as an 8-bit parallel peripheral. The host has three active-low strobes: select, read and write. It shares a data bus with the controller. While the host holds select and read low, the port drives the contents of one internal 8-bit latch onto the bus. When the host releases its write strobe while select is low, the port takes the bus value into that same latch. The latch therefore carries data in both directions.

The host strobes and the bus are asynchronous to the controller clock, so the port passes them through a synchroniser before using them. A write is recognised on the synchronised rising edge of the write strobe. The captured data is the synchronised bus value sampled while the strobe was still low, so the bus only has to be stable around the end of the write pulse.

The controller side can do three things. It can load the latch as two nibbles, the upper nibble from its accumulator and the lower nibble from memory. It can read both nibbles back at any time. It can raise a ready flag, which a host write then clears, and this gives the two sides a handshake. An output-enable bit from the controller's enable register is still wired in, but in this mode it has no effect on the bus drivers.

Top module: `hpp_port`

## Requirements
- R1: After a synchronous reset, the latch reads 0x00, `ready` is 0 and `host_data_oe` is 0.
- R2: While `host_cs_n` and `host_rd_n` are both low, `host_data_oe` is 1 and `host_data_out` equals the latch. This holds no later than the third rising clock edge after both strobes go low.
- R3: Whenever `host_cs_n` or `host_rd_n` is high, `host_data_oe` returns to 0 within three clock edges, which leaves the bus at high impedance.
- R4: A low-then-high pulse on `host_wr_n` with `host_cs_n` low stores the value held on `host_data_in` during the pulse into the latch.
- R5: With `host_cs_n` high, pulses on `host_wr_n` and `host_rd_n` leave the latch unchanged and do not drive the bus.
- R6: A recognised host write clears `ready`.
- R7: A one-cycle pulse on `ctl_ready_set` sets `ready` on the next clock edge. If a host write is recognised in the same cycle, the write takes precedence.
- R8: A one-cycle pulse on `ctl_load` loads the latch with {`ctl_acc`, `ctl_mem`}, with the accumulator in bits 7:4. `ctl_latch_hi` and `ctl_latch_lo` always show bits 7:4 and 3:0 of the latch.
- R9: `ctl_drv_en` has no effect on `host_data_oe` or on `host_data_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cs_n | input | 1 | Host select strobe, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_data_in | input | 8 | Bus value seen at the pins |
| host_data_out | output | 8 | Value to drive onto the bus |
| host_data_oe | output | 1 | Bus driver enable; 0 means high impedance |
| ctl_load | input | 1 | Load the latch from the controller nibbles |
| ctl_acc | input | 4 | Accumulator nibble, goes to latch bits 7:4 |
| ctl_mem | input | 4 | Memory nibble, goes to latch bits 3:0 |
| ctl_ready_set | input | 1 | Set the ready flag |
| ctl_drv_en | input | 1 | Enable-register driver bit, ignored in this mode |
| ctl_latch_hi | output | 4 | Latch bits 7:4, read back by the controller |
| ctl_latch_lo | output | 4 | Latch bits 3:0, read back by the controller |
| ready | output | 1 | Ready/interrupt flag to the host |

## Verification
Any corruption of the latch shows up on `ctl_latch_hi`/`ctl_latch_lo` on the very next cycle. It also appears on the bus during the next host read, about three cycles after the read starts. A synchroniser or edge detector that is out of step would either miss a write or capture a stale bus value, and that becomes visible about three cycles after the write strobe is released. A bad ready flag or a wrong driver enable shows up directly on `ready` and `host_data_oe` within one to three cycles. The bench checks each of these at a fixed number of edges after its stimulus.

// File: rtl/hpp_pkg.sv
package hpp_pkg;

    localparam int DATA_W = 8;
    localparam int NIB_W  = DATA_W / 2;

    typedef struct packed {
        logic cs_n;
        logic rd_n;
        logic wr_n;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{cs_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1};

    function automatic logic [DATA_W-1:0] join_nibbles(
        input logic [NIB_W-1:0] hi,
        input logic [NIB_W-1:0] lo
    );
        return {hi, lo};
    endfunction

endpackage

// File: rtl/hpp_sync.sv
module hpp_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[0] <= RST_VAL;
                    else     stg[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[i] <= RST_VAL;
                    else     stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/hpp_latch_ctrl.sv
module hpp_latch_ctrl
    import hpp_pkg::*;
#(
    parameter int W = DATA_W,
    localparam int NW = W / 2
) (
    input  logic          clk,
    input  logic          rst,
    input  strobe_t       st_s,
    input  logic [W-1:0]  bus_s,
    input  logic          ctl_load,
    input  logic [NW-1:0] ctl_acc,
    input  logic [NW-1:0] ctl_mem,
    input  logic          ctl_ready_set,
    output logic [W-1:0]  latch_q,
    output logic          ready_q,
    output logic          drive
);
    strobe_t      st_d;
    logic [W-1:0] bus_d;
    logic         wr_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_d  <= STROBE_IDLE;
            bus_d <= '0;
        end else begin
            st_d  <= st_s;
            bus_d <= bus_s;
        end
    end

    // Write completes when the strobe returns high; select qualified while low.
    assign wr_rise = !st_d.wr_n && st_s.wr_n && !st_d.cs_n;
    assign drive   = !st_s.cs_n && !st_s.rd_n;

    always_ff @(posedge clk) begin
        if (rst)           latch_q <= '0;
        else if (wr_rise)  latch_q <= bus_d;
        else if (ctl_load) latch_q <= {ctl_acc, ctl_mem};
    end

    always_ff @(posedge clk) begin
        if (rst)                ready_q <= 1'b0;
        else if (wr_rise)       ready_q <= 1'b0;
        else if (ctl_ready_set) ready_q <= 1'b1;
    end

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (latch_q == '0 && !ready_q)); // R1
    AST_WRITE_CLEARS_READY: assert property (@(posedge clk) disable iff (rst)
        wr_rise |=> !ready_q); // R6
    AST_READY_SET: assert property (@(posedge clk) disable iff (rst)
        (ctl_ready_set && !wr_rise) |=> ready_q); // R7
    AST_CTL_LOAD: assert property (@(posedge clk) disable iff (rst)
        (ctl_load && !wr_rise) |=> latch_q == {$past(ctl_acc), $past(ctl_mem)}); // R8
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!wr_rise && !ctl_load) |=> $stable(latch_q)); // R5
endmodule

// File: rtl/hpp_port.sv
module hpp_port
    import hpp_pkg::*;
#(
    parameter int W = DATA_W,
    parameter int SYNC_STAGES = 2,
    localparam int NW = W / 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_cs_n,
    input  logic          host_rd_n,
    input  logic          host_wr_n,
    input  logic [W-1:0]  host_data_in,
    output logic [W-1:0]  host_data_out,
    output logic          host_data_oe,
    input  logic          ctl_load,
    input  logic [NW-1:0] ctl_acc,
    input  logic [NW-1:0] ctl_mem,
    input  logic          ctl_ready_set,
    input  logic          ctl_drv_en,
    output logic [NW-1:0] ctl_latch_hi,
    output logic [NW-1:0] ctl_latch_lo,
    output logic          ready
);
    localparam int SW = $bits(strobe_t);

    strobe_t      st_raw, st_s;
    logic [W-1:0] bus_s, latch;

    assign st_raw = '{cs_n: host_cs_n, rd_n: host_rd_n, wr_n: host_wr_n};

    hpp_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(STROBE_IDLE)) u_strobe_sync (
        .clk(clk), .rst(rst), .d(st_raw), .q(st_s)
    );

    hpp_sync #(.W(W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
        .clk(clk), .rst(rst), .d(host_data_in), .q(bus_s)
    );

    hpp_latch_ctrl #(.W(W)) u_ctrl (
        .clk(clk), .rst(rst), .st_s(st_s), .bus_s(bus_s),
        .ctl_load(ctl_load), .ctl_acc(ctl_acc), .ctl_mem(ctl_mem),
        .ctl_ready_set(ctl_ready_set),
        .latch_q(latch), .ready_q(ready), .drive(host_data_oe)
    );

    // The driver-enable bit from the enable register is deliberately unused here.
    assign host_data_out = latch;
    assign ctl_latch_hi  = latch[W-1:NW];
    assign ctl_latch_lo  = latch[NW-1:0];

    AST_OE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (rst)
        host_data_oe |-> !st_s.cs_n); // R3
    AST_OE_DATA_IS_LATCH: assert property (@(posedge clk) disable iff (rst)
        host_data_oe |-> host_data_out == join_nibbles(ctl_latch_hi, ctl_latch_lo)); // R2
    AST_DRV_EN_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!ctl_drv_en && !st_s.cs_n && !st_s.rd_n) |-> host_data_oe); // R9
endmodule

// File: tb/hpp_port_tb.sv
module hpp_port_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       cs_n, rd_n, wr_n;
    logic [7:0] din, dout;
    logic       oe, ld, rset, drv_en, rdy;
    logic [3:0] acc, mem, lhi, llo;
    int         n_cmp = 0;
    int         n_bad = 0;
    bit         done  = 1'b0;

    always #2.5 clk = ~clk;

    hpp_port dut_i (
        .clk(clk), .rst(rst), .host_cs_n(cs_n), .host_rd_n(rd_n), .host_wr_n(wr_n),
        .host_data_in(din), .host_data_out(dout), .host_data_oe(oe),
        .ctl_load(ld), .ctl_acc(acc), .ctl_mem(mem), .ctl_ready_set(rset),
        .ctl_drv_en(drv_en), .ctl_latch_hi(lhi), .ctl_latch_lo(llo), .ready(rdy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write(input logic [7:0] v, input bit sel);
        din = v; cs_n = !sel; wr_n = 1'b0;
        wait_n(3);
        wr_n = 1'b1;
        wait_n(2);
        cs_n = 1'b1; din = 8'h00;
        wait_n(4);
    endtask

    task automatic host_read_check(input logic [7:0] exp, input string req);
        cs_n = 1'b0; rd_n = 1'b0;
        wait_n(3);
        chk(oe == 1'b1, req, oe, 1);
        chk(dout == exp, req, dout, exp);
        rd_n = 1'b1; cs_n = 1'b1;
        wait_n(3);
        chk(oe == 1'b0, "R3", oe, 0);
    endtask

    task automatic t_reset;
        rst = 1'b1; wait_n(3); rst = 1'b0; wait_n(1);
        chk({lhi, llo} == 8'h00, "R1 latch", {lhi, llo}, 0);
        chk(rdy == 1'b0, "R1 ready", rdy, 0);
        chk(oe == 1'b0, "R1 oe", oe, 0);
    endtask

    task automatic t_write_read;
        host_write(8'hA5, 1'b1);
        chk({lhi, llo} == 8'hA5, "R4", {lhi, llo}, 8'hA5);
        host_read_check(8'hA5, "R2");
        host_write(8'h3C, 1'b1);
        chk({lhi, llo} == 8'h3C, "R4", {lhi, llo}, 8'h3C);
        host_read_check(8'h3C, "R2");
    endtask

    task automatic t_read_no_cs;
        cs_n = 1'b1; rd_n = 1'b0;
        wait_n(4);
        chk(oe == 1'b0, "R3 rd without select", oe, 0);
        rd_n = 1'b1; wait_n(2);
    endtask

    task automatic t_cs_ignored;
        host_write(8'hFF, 1'b0);
        chk({lhi, llo} == 8'h3C, "R5", {lhi, llo}, 8'h3C);
        host_read_check(8'h3C, "R5");
    endtask

    task automatic t_ready;
        rset = 1'b1; wait_n(1); rset = 1'b0;
        chk(rdy == 1'b1, "R7", rdy, 1);
        wait_n(2);
        chk(rdy == 1'b1, "R7 held", rdy, 1);
        host_write(8'h11, 1'b1);
        chk(rdy == 1'b0, "R6", rdy, 0);
        chk({lhi, llo} == 8'h11, "R4", {lhi, llo}, 8'h11);
    endtask

    task automatic t_ctl_load;
        acc = 4'h9; mem = 4'h6; ld = 1'b1; wait_n(1); ld = 1'b0;
        chk(lhi == 4'h9, "R8 hi", lhi, 9);
        chk(llo == 4'h6, "R8 lo", llo, 6);
        host_read_check(8'h96, "R8");
    endtask

    task automatic t_drv_en;
        drv_en = 1'b0;
        host_read_check(8'h96, "R9 en=0");
        drv_en = 1'b1;
        wait_n(3);
        chk(oe == 1'b0, "R9 idle", oe, 0);
        host_read_check(8'h96, "R9 en=1");
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; din = 8'h00;
        ld = 1'b0; acc = 4'h0; mem = 4'h0; rset = 1'b0; drv_en = 1'b0;
        rst = 1'b1;
        wait_n(1);
        t_reset;
        t_write_read;
        t_read_no_cs;
        t_cs_ignored;
        t_ready;
        t_ctl_load;
        t_drv_en;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule